// File: doc/BRIEF.md
# Next-PC and branch resolution unit

This block is purely combinational. It works out the program counter a single-cycle 32-bit processor fetches from after the current instruction. It takes four inputs: the current PC, the instruction word, and the two values read from the register file for the instruction's first (rs) and second (rt) source fields. It returns the next PC, a taken flag, and a link-write request that carries the register index and the return address. The PC register sits outside the block and loads the next PC on its own clock edge.

The block decodes every control-flow form of the instruction set:
- sequential flow;
- absolute region jumps;
- jumps through a register;
- branches that compare two registers;
- branches that compare one register against zero;
- the jump-and-link call.

Branch offsets are sign-extended, scaled by four and added to the incremented PC. Region jumps keep the top four bits of the incremented PC. A call returns to the address two instructions past the current one.

Top module: `npc_unit`

## Requirements
- R1: Any instruction that is not a control-flow form drives next PC = PC+4 and taken low. Opcode 0 with a function code other than 0x08 counts as not a control-flow form.
- R2: Opcode 0x02 (instruction bits 31:26) always takes. Its next PC is bits 31:28 of PC+4, then the 26-bit field in instruction bits 25:0, then two zero bits.
- R3: Opcode 0x00 with function code 0x08 (bits 5:0) always takes, and its next PC is the rs register value unchanged.
- R4: Opcode 0x04 takes when rs equals rt, and opcode 0x05 takes when they differ. The taken target is PC+4 plus the sign-extended 16-bit field in bits 15:0 shifted left by two, computed modulo 2^32. When not taken, next PC is PC+4.
- R5: For opcode 0x01, the rt field (bits 20:16) selects the test. Value 0 takes when rs is negative, value 1 takes when rs is zero or positive, and any other value behaves as in R1. The target is the same as in R4.
- R6: Opcode 0x06 takes when rs is zero or negative, and opcode 0x07 takes when rs is strictly positive. rs is read as a signed 32-bit two's-complement value, and the target is the same as in R4.
- R7: Opcode 0x03 jumps exactly as in R2. It also raises the link-write request with register index 31 and link value PC+8.
- R8: For every opcode other than 0x03, the link-write request is low.
- R9: For the forms in R2 and R7, the next PC always lies in the same 256 MB region as PC+4, including when PC+4 wraps past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Instruction word being executed |
| rs_val_i | input | 32 | Register value read for the rs field |
| rt_val_i | input | 32 | Register value read for the rt field |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | High when control leaves the sequential path |
| link_we_o | output | 1 | Request to write the return address |
| link_idx_o | output | 5 | Register index for the return address |
| link_data_o | output | 32 | Return address (PC+8) |

## Verification
The checks assume that the inputs hold steady between evaluations. They also assume that rs_val_i and rt_val_i are full 32-bit words with no unknown bits, so that every equality and sign test resolves. The bench changes inputs only on one clock edge and samples outputs on the opposite edge. It drives only fully defined values, including the sign-boundary words 0x80000000, 0x7FFFFFFF and zero, and PCs near the top of the address space so that the incremented PC wraps.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int XLEN       = 32;
  localparam int OP_W       = 6;
  localparam int IDX_W      = 26;
  localparam int OFF_W      = 16;
  localparam int REG_W      = 5;
  localparam int ALIGN_BITS = 2;
  localparam int REGION_LO  = IDX_W + ALIGN_BITS;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OP_W-1:0] OP_REGIMM  = 6'h01;
  localparam logic [OP_W-1:0] OP_JMP     = 6'h02;
  localparam logic [OP_W-1:0] OP_CALL    = 6'h03;
  localparam logic [OP_W-1:0] OP_BREQ    = 6'h04;
  localparam logic [OP_W-1:0] OP_BRNE    = 6'h05;
  localparam logic [OP_W-1:0] OP_BRLEZ   = 6'h06;
  localparam logic [OP_W-1:0] OP_BRGTZ   = 6'h07;
  localparam logic [OP_W-1:0] FN_JREG    = 6'h08;

  typedef enum logic [3:0] {
    CF_NONE, CF_JUMP, CF_CALL, CF_JREG,
    CF_EQ, CF_NE, CF_LTZ, CF_GEZ, CF_LEZ, CF_GTZ
  } cf_kind_e;

  function automatic logic [XLEN-1:0] seq_step(input logic [XLEN-1:0] pc,
                                               input int unsigned bytes);
    return pc + XLEN'(bytes);
  endfunction

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0]  pc4,
                                                 input logic [OFF_W-1:0] off);
    logic [XLEN-1:0] sx;
    sx = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
    return pc4 + (sx << ALIGN_BITS);
  endfunction

  function automatic logic [XLEN-1:0] region_jump(input logic [XLEN-1:0]  pc4,
                                                  input logic [IDX_W-1:0] idx);
    return {pc4[XLEN-1:REGION_LO], idx, {ALIGN_BITS{1'b0}}};
  endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] rt_field_i,
  input  logic [OP_W-1:0]  fn_i,
  output cf_kind_e         kind_o
);

  always_comb begin
    kind_o = CF_NONE;
    case (op_i)
      OP_SPECIAL: kind_o = (fn_i == FN_JREG) ? CF_JREG : CF_NONE;
      OP_REGIMM: begin
        if (rt_field_i == REG_W'(0))      kind_o = CF_LTZ;
        else if (rt_field_i == REG_W'(1)) kind_o = CF_GEZ;
        else                              kind_o = CF_NONE;
      end
      OP_JMP:    kind_o = CF_JUMP;
      OP_CALL:   kind_o = CF_CALL;
      OP_BREQ:   kind_o = CF_EQ;
      OP_BRNE:   kind_o = CF_NE;
      OP_BRLEZ:  kind_o = CF_LEZ;
      OP_BRGTZ:  kind_o = CF_GTZ;
      default:   kind_o = CF_NONE;
    endcase
  end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  cf_kind_e        kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            take_o
);

  logic neg, zero, same;

  assign neg  = a_i[XLEN-1];
  assign zero = (a_i == '0);
  assign same = (a_i == b_i);

  always_comb begin
    case (kind_i)
      CF_JUMP, CF_CALL, CF_JREG: take_o = 1'b1;
      CF_EQ:   take_o = same;
      CF_NE:   take_o = !same;
      CF_LTZ:  take_o = neg;
      CF_GEZ:  take_o = !neg;
      CF_LEZ:  take_o = neg || zero;
      CF_GTZ:  take_o = !neg && !zero;
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int INSTR_BYTES = 4
) (
  input  cf_kind_e         kind_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  reg_i,
  output logic [XLEN-1:0]  seq_pc_o,
  output logic [XLEN-1:0]  link_pc_o,
  output logic [XLEN-1:0]  target_o
);

  logic [XLEN-1:0] jmp_pc, br_pc;

  assign seq_pc_o  = seq_step(pc_i, INSTR_BYTES);
  assign link_pc_o = seq_step(pc_i, 2 * INSTR_BYTES);
  assign jmp_pc    = region_jump(seq_pc_o, idx_i);
  assign br_pc     = rel_target(seq_pc_o, idx_i[OFF_W-1:0]);

  always_comb begin
    case (kind_i)
      CF_JUMP, CF_CALL: target_o = jmp_pc;
      CF_JREG:          target_o = reg_i;
      CF_NONE:          target_o = seq_pc_o;
      default:          target_o = br_pc;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int LINK_REG    = 31,
  parameter int INSTR_BYTES = 4
) (
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] next_pc_o,
  output logic        taken_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_data_o
);

  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

  cf_kind_e        kind;
  logic            take;
  logic [XLEN-1:0] seq_pc, link_pc, target;

  npc_decode u_dec (
    .op_i       (instr_i[31:26]),
    .rt_field_i (instr_i[20:16]),
    .fn_i       (instr_i[5:0]),
    .kind_o     (kind)
  );

  npc_cond u_cond (
    .kind_i (kind),
    .a_i    (rs_val_i),
    .b_i    (rt_val_i),
    .take_o (take)
  );

  npc_target #(.INSTR_BYTES(INSTR_BYTES)) u_tgt (
    .kind_i    (kind),
    .pc_i      (pc_i),
    .idx_i     (instr_i[IDX_W-1:0]),
    .reg_i     (rs_val_i),
    .seq_pc_o  (seq_pc),
    .link_pc_o (link_pc),
    .target_o  (target)
  );

  assign next_pc_o   = take ? target : seq_pc;
  assign taken_o     = take;
  assign link_we_o   = (kind == CF_CALL);
  assign link_idx_o  = LINK_IDX;
  assign link_data_o = link_pc;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic [31:0] pc_i,
  input logic [5:0]  op_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i,
  input logic [31:0] next_pc_o,
  input logic        taken_o,
  input logic        link_we_o,
  input logic [4:0]  link_idx_o,
  input logic [31:0] link_data_o
);

  logic [31:0] pc4;
  assign pc4 = pc_i + 32'd4;

  always_comb begin
    // R1
    seq_path_chk: assert (taken_o || next_pc_o == pc4);
    // R8
    link_only_call_chk: assert (!link_we_o || op_i == 6'h03);
    // R7
    link_value_chk: assert (!link_we_o || (link_data_o == pc_i + 32'd8 && link_idx_o == 5'd31));
    // R9
    region_keep_chk: assert (!(op_i == 6'h02 || op_i == 6'h03) ||
                             (taken_o && next_pc_o[31:28] == pc4[31:28] && next_pc_o[1:0] == 2'b00));
    // R4
    eq_branch_chk: assert (op_i != 6'h04 || taken_o == (rs_val_i == rt_val_i));
    // R6
    gtz_branch_chk: assert (op_i != 6'h07 || taken_o == ($signed(rs_val_i) > 0));
  end

endmodule

bind npc_unit npc_unit_chk u_chk (
  .pc_i        (pc_i),
  .op_i        (instr_i[31:26]),
  .rs_val_i    (rs_val_i),
  .rt_val_i    (rt_val_i),
  .next_pc_o   (next_pc_o),
  .taken_o     (taken_o),
  .link_we_o   (link_we_o),
  .link_idx_o  (link_idx_o),
  .link_data_o (link_data_o)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pc, instr, rs_v, rt_v;
  logic [31:0] next_pc, link_data;
  logic        taken, link_we;
  logic [4:0]  link_idx;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  npc_unit u_npc_unit (
    .pc_i(pc), .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v),
    .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
    .link_idx_o(link_idx), .link_data_o(link_data)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
  } stim_t;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rsf,
                                     input logic [4:0] rtf, input logic [15:0] low);
    return {op, rsf, rtf, low};
  endfunction

  localparam int NV = 14;
  localparam stim_t TBL [NV] = '{
    '{32'h0000_1000, 32'h0022_1821, 32'h5, 32'h6},          // R1 addu
    '{32'h0000_2000, 32'h8C22_0010, 32'h5, 32'h6},          // R1 load opcode
    '{32'h1234_5678, 32'h0800_0100, 32'h0, 32'h0},          // R2 jump
    '{32'h0000_3000, 32'h0060_0008, 32'h0ABC_DEF0, 32'h0},  // R3 jr
    '{32'h0000_4000, 32'h1022_0003, 32'h7, 32'h7},          // R4 beq taken
    '{32'h0000_4000, 32'h1022_0003, 32'h7, 32'h8},          // R4 beq not
    '{32'h0000_5000, 32'h1422_FFFE, 32'h1, 32'h2},          // R4 bne backward
    '{32'h0000_6000, 32'h0420_0010, 32'hFFFF_FFFF, 32'h0},  // R5 ltz
    '{32'h0000_6000, 32'h0421_0010, 32'hFFFF_FFFF, 32'h0},  // R5 gez not
    '{32'h0000_7000, 32'h1820_0020, 32'h8000_0000, 32'h0},  // R6 lez neg
    '{32'h0000_7000, 32'h1C20_0020, 32'h7FFF_FFFF, 32'h0},  // R6 gtz
    '{32'h0000_7000, 32'h1C20_0020, 32'h0, 32'h0},          // R6 gtz zero
    '{32'h1000_0000, 32'h0C00_0040, 32'h0, 32'h0},          // R7 call
    '{32'hFFFF_FFF8, 32'h1000_0001, 32'h0, 32'h0}           // R4 wrap
  };

  task automatic model(input logic [31:0] p, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] nxt, output logic tk, output logic lw);
    logic [31:0] pc4, bt, jt;
    logic [5:0] op;
    op  = ins[31:26];
    pc4 = p + 32'd4;
    bt  = pc4 + ({{16{ins[15]}}, ins[15:0]} * 32'd4);
    jt  = (pc4 & 32'hF000_0000) | ({6'b0, ins[25:0]} * 32'd4);
    tk = 0; nxt = pc4; lw = (op == 6'd3);
    if (op == 6'd2 || op == 6'd3) begin tk = 1; nxt = jt; end
    else if (op == 6'd0 && ins[5:0] == 6'd8) begin tk = 1; nxt = a; end
    else if (op == 6'd4) tk = (a == b);
    else if (op == 6'd5) tk = (a != b);
    else if (op == 6'd1 && ins[20:16] == 5'd0) tk = $signed(a) < 0;
    else if (op == 6'd1 && ins[20:16] == 5'd1) tk = $signed(a) >= 0;
    else if (op == 6'd6) tk = $signed(a) <= 0;
    else if (op == 6'd7) tk = $signed(a) > 0;
    if (tk && op >= 6'd4) nxt = bt;
    if (tk && op == 6'd1) nxt = bt;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] p, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    pc = p; instr = ins; rs_v = a; rt_v = b;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [31:0] enpc,
                            input logic etk, input logic elw);
    chk({req, " next_pc"}, next_pc, enpc);
    chk({req, " taken"}, {31'b0, taken}, {31'b0, etk});
    chk({req, " link_we"}, {31'b0, link_we}, {31'b0, elw});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] enpc;
    logic etk, elw;
    pc = '0; instr = '0; rs_v = '0; rt_v = '0;
    // Idle state with all-zero inputs: R1 and R8
    @(negedge clk);
    expect_out("R1 idle", 32'h4, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].pc, TBL[i].ins, TBL[i].a, TBL[i].b);
      model(TBL[i].pc, TBL[i].ins, TBL[i].a, TBL[i].b, enpc, etk, elw);
      expect_out($sformatf("table[%0d] R1..R8", i), enpc, etk, elw);
      if (elw) begin
        chk("R7 link data", link_data, TBL[i].pc + 32'd8);
        chk("R7 link idx", {27'b0, link_idx}, 32'd31);
      end
    end

    // R2 plain jump
    drive(32'h1000_0000, mk(6'h02, 5'd0, 5'd0, 16'h0010), 32'h0, 32'h0);
    expect_out("R2 jump", 32'h1000_0040, 1'b1, 1'b0);
    // R9 region taken from PC+4 crossing into next region
    drive(32'h2FFF_FFFC, 32'h0BFF_FFFF, 32'h0, 32'h0);
    expect_out("R9 region cross", 32'h3FFF_FFFC, 1'b1, 1'b0);
    // R9 PC+4 wraps to zero
    drive(32'hFFFF_FFFC, mk(6'h02, 5'd0, 5'd0, 16'h0001), 32'h0, 32'h0);
    expect_out("R9 wrap", 32'h0000_0004, 1'b1, 1'b0);
    // R7 call
    drive(32'h0000_0400, mk(6'h03, 5'd0, 5'd0, 16'h0100), 32'h0, 32'h0);
    expect_out("R7 call", 32'h0000_0400, 1'b1, 1'b1);
    chk("R7 link data", link_data, 32'h0000_0408);
    chk("R7 link idx", {27'b0, link_idx}, 32'd31);
    // R3 jump register
    drive(32'h0000_0800, mk(6'h00, 5'd3, 5'd0, 16'h0008), 32'hDEAD_BEE0, 32'h0);
    expect_out("R3 jreg", 32'hDEAD_BEE0, 1'b1, 1'b0);
    // R1 opcode 0 other function
    drive(32'h0000_0800, mk(6'h00, 5'd3, 5'd4, 16'h0009), 32'hDEAD_BEE0, 32'h0);
    expect_out("R1 op0 fn9", 32'h0000_0804, 1'b0, 1'b0);
    // R4 equal backward offset -1
    drive(32'h0000_0100, mk(6'h04, 5'd1, 5'd2, 16'hFFFF), 32'h5, 32'h5);
    expect_out("R4 beq back", 32'h0000_0100, 1'b1, 1'b0);
    // R4 ne with equal operands not taken
    drive(32'h0000_0100, mk(6'h05, 5'd1, 5'd2, 16'hFFFF), 32'h5, 32'h5);
    expect_out("R4 bne equal", 32'h0000_0104, 1'b0, 1'b0);
    // R4 maximum forward offset
    drive(32'h0000_0000, mk(6'h04, 5'd1, 5'd2, 16'h7FFF), 32'h9, 32'h9);
    expect_out("R4 max fwd", 32'h0002_0000, 1'b1, 1'b0);
    // R5 unknown sub-operation is sequential
    drive(32'h0000_0200, mk(6'h01, 5'd1, 5'd2, 16'h0010), 32'hFFFF_FFFF, 32'h0);
    expect_out("R5 subop2", 32'h0000_0204, 1'b0, 1'b0);
    // R5 ltz on most negative
    drive(32'h0000_0200, mk(6'h01, 5'd1, 5'd0, 16'h0010), 32'h8000_0000, 32'h0);
    expect_out("R5 ltz min", 32'h0000_0244, 1'b1, 1'b0);
    // R5 gez on zero
    drive(32'h0000_0200, mk(6'h01, 5'd1, 5'd1, 16'h0010), 32'h0, 32'h0);
    expect_out("R5 gez zero", 32'h0000_0244, 1'b1, 1'b0);
    // R6 lez on zero
    drive(32'h0000_0300, mk(6'h06, 5'd1, 5'd0, 16'h0004), 32'h0, 32'h0);
    expect_out("R6 lez zero", 32'h0000_0314, 1'b1, 1'b0);
    // R6 lez on positive
    drive(32'h0000_0300, mk(6'h06, 5'd1, 5'd0, 16'h0004), 32'h1, 32'h0);
    expect_out("R6 lez pos", 32'h0000_0304, 1'b0, 1'b0);
    // R6 gtz on most negative
    drive(32'h0000_0300, mk(6'h07, 5'd1, 5'd0, 16'h0004), 32'h8000_0000, 32'h0);
    expect_out("R6 gtz neg", 32'h0000_0304, 1'b0, 1'b0);
    // R8 no link on jump register
    drive(32'h0000_0900, mk(6'h00, 5'd31, 5'd0, 16'h0008), 32'h0000_1000, 32'h0);
    chk("R8 no link on jreg", {31'b0, link_we}, 32'h0);

    finish_run();
  end

endmodule